// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the 12-bit fetch address of a small 8-bit controller whose program store holds 4K words. Each instruction cycle is marked by an advance strobe. On that strobe the unit takes one of several actions, chosen by decoded control strobes: it steps to the next word, branches inside a 1K page, calls a subroutine, returns from one, or enters the interrupt handler. A synchronous restart strobe sends the address back to zero at any time.

Branch and call strobes carry only a 10-bit in-page target. The upper two address bits come from a separate page-select register, which has its own write strobe. Calls and interrupt entry save the address of the following word on an eight-entry circular return stack. Returns reload the full 12-bit address from that stack. The stack reports no overflow and no underflow: a ninth save silently replaces the oldest entry, and a return from an empty stack reads whatever entry the wrapped pointer selects.

Top module: `pc_stack_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x000 and the page register is 0. A high restart_i sets pc_o to 0x000 on the next clock edge, whatever the value of adv_i.
- R2: When adv_i is high and no other action strobe is high, pc_o increments by one on the next edge, and 0xFFF wraps to 0x000.
- R3: While adv_i is low and restart_i is low, pc_o keeps its value, and the jump, call, return and interrupt strobes have no effect.
- R4: On a jump (adv_i and jmp_i), pc_o becomes {page, target_i}. The page register supplies bits 11:10 and target_i supplies bits 9:0.
- R5: page_wr_i loads page_i into the page register on any clock edge. A jump or call in the same cycle still uses the old page. The new page applies from the next cycle onward.
- R6: On a call (adv_i and call_i), pc_o becomes {page, target_i}, and the stack saves the old pc_o + 1 (taken modulo 4096).
- R7: On a return (adv_i and ret_i), pc_o is loaded in all 12 bits from the most recently saved stack entry, and that entry is removed.
- R8: On an interrupt (adv_i and irq_i), pc_o becomes 0x008, and the stack saves the old pc_o + 1.
- R9: When several strobes are high together, exactly one action takes place, in this priority order: restart_i, irq_i, ret_i, call_i, jmp_i, then increment.
- R10: The stack holds 8 entries in a circular buffer. After 9 saves, 8 returns yield the saves in the order 9th, 8th, …, 2nd. A further return then yields the 9th save again.
- R11: When restart_i and irq_i are high in the same cycle, pc_o becomes 0x000 and nothing is saved. The restart also empties the stack pointer, so the next return reads the stack slot just below slot 0 (slot 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Instruction-cycle advance enable |
| restart_i | input | 1 | Synchronous restart to address 0x000 |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| call_i | input | 1 | Call strobe |
| jmp_i | input | 1 | In-page jump strobe |
| target_i | input | 10 | In-page target address |
| page_wr_i | input | 1 | Page register write strobe |
| page_i | input | 2 | Page value to write |
| pc_o | output | 12 | Current fetch address |

## Verification
The next-address selection is exercised with plain increments, including the 0xFFF wrap. It is also driven with jumps under different pages and with a page write in the same cycle as a jump, which separates the old page from the new one. Nested call/return pairs and interrupt entry show that the saved value is pc+1 and that returns restore all 12 bits. Combined strobes check each level of the priority chain. A nine-deep call chain followed by nine returns, plus a restart that coincides with an interrupt, expose the circular overwrite and the pointer clear: the value returned after the restart differs from what an uncleared pointer would give.

// File: rtl/pc_stack_pkg.sv
package pc_stack_pkg;
  localparam int unsigned PC_W_DEF  = 12;
  localparam int unsigned LOW_W_DEF = 10;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned RST_VEC_DEF = 0;
  localparam int unsigned IRQ_VEC_DEF = 8;

  typedef enum logic [2:0] {
    NX_HOLD, NX_RST, NX_IRQ, NX_RET, NX_CALL, NX_JMP, NX_INC
  } nx_sel_e;
endpackage

// File: rtl/page_sel_reg.sv
module page_sel_reg #(
  parameter int unsigned PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] d_i,
  output logic [PAGE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 8   // power of two: pointer wraps naturally
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] rd_idx;

  assign rd_idx = sp_q - PW'(1);
  assign top_o  = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (clr_i)   sp_q <= '0;
    else if (push_i)  sp_q <= sp_q + PW'(1);
    else if (pop_i)   sp_q <= rd_idx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (push_i && !clr_i && sp_q == PW'(g))
        mem_q[g] <= data_i;
    end
  end

  AST_PUSH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R9
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clr_i |=> sp_q == $past(sp_q) + PW'(1)); // R10
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !clr_i |=> sp_q == $past(sp_q) - PW'(1)); // R7
  AST_CLR_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sp_q == '0); // R11
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_stack_pkg::*;
#(
  parameter int unsigned PC_W    = PC_W_DEF,
  parameter int unsigned LOW_W   = LOW_W_DEF,
  parameter int unsigned RST_VEC = RST_VEC_DEF,
  parameter int unsigned IRQ_VEC = IRQ_VEC_DEF
) (
  input  logic                  adv_i,
  input  logic                  restart_i,
  input  logic                  irq_i,
  input  logic                  ret_i,
  input  logic                  call_i,
  input  logic                  jmp_i,
  input  logic [LOW_W-1:0]      target_i,
  input  logic [PC_W-LOW_W-1:0] page_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [PC_W-1:0]       top_i,
  output logic [PC_W-1:0]       pc_d_o,
  output logic                  push_o,
  output logic                  pop_o,
  output logic                  clr_o,
  output logic [PC_W-1:0]       push_data_o
);
  nx_sel_e sel;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc      = pc_i + PC_W'(1);
  assign push_data_o = pc_inc;

  always_comb begin
    if (restart_i)       sel = NX_RST;
    else if (!adv_i)     sel = NX_HOLD;
    else if (irq_i)      sel = NX_IRQ;
    else if (ret_i)      sel = NX_RET;
    else if (call_i)     sel = NX_CALL;
    else if (jmp_i)      sel = NX_JMP;
    else                 sel = NX_INC;
  end

  always_comb begin
    push_o = 1'b0;
    pop_o  = 1'b0;
    clr_o  = 1'b0;
    unique case (sel)
      NX_RST:  begin pc_d_o = PC_W'(RST_VEC); clr_o = 1'b1; end
      NX_IRQ:  begin pc_d_o = PC_W'(IRQ_VEC); push_o = 1'b1; end
      NX_RET:  begin pc_d_o = top_i; pop_o = 1'b1; end
      NX_CALL: begin pc_d_o = {page_i, target_i}; push_o = 1'b1; end
      NX_JMP:  pc_d_o = {page_i, target_i};
      NX_INC:  pc_d_o = pc_inc;
      default: pc_d_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pc_stack_pkg::*;
#(
  parameter int unsigned PC_W    = PC_W_DEF,
  parameter int unsigned LOW_W   = LOW_W_DEF,
  parameter int unsigned DEPTH   = DEPTH_DEF,
  parameter int unsigned RST_VEC = RST_VEC_DEF,
  parameter int unsigned IRQ_VEC = IRQ_VEC_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic                  restart_i,
  input  logic                  irq_i,
  input  logic                  ret_i,
  input  logic                  call_i,
  input  logic                  jmp_i,
  input  logic [LOW_W-1:0]      target_i,
  input  logic                  page_wr_i,
  input  logic [PC_W-LOW_W-1:0] page_i,
  output logic [PC_W-1:0]       pc_o
);
  localparam int unsigned PAGE_W = PC_W - LOW_W;

  logic [PAGE_W-1:0] page_q;
  logic [PC_W-1:0]   pc_q, pc_d, top, push_data;
  logic              push, pop, clr;

  page_sel_reg #(.PAGE_W(PAGE_W)) i_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(page_wr_i), .d_i(page_i), .q_o(page_q)
  );

  pc_next_sel #(
    .PC_W(PC_W), .LOW_W(LOW_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) i_sel (
    .adv_i(adv_i), .restart_i(restart_i), .irq_i(irq_i), .ret_i(ret_i),
    .call_i(call_i), .jmp_i(jmp_i), .target_i(target_i), .page_i(page_q),
    .pc_i(pc_q), .top_i(top), .pc_d_o(pc_d), .push_o(push), .pop_o(pop),
    .clr_o(clr), .push_data_o(push_data)
  );

  ret_stack #(.W(PC_W), .DEPTH(DEPTH)) i_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .push_i(push), .pop_i(pop),
    .data_i(push_data), .top_o(top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_W'(RST_VEC);
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_RESTART_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pc_o == PC_W'(RST_VEC)); // R1
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !restart_i && !irq_i && !ret_i && !call_i && !jmp_i
    |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !restart_i |=> $stable(pc_o)); // R3
  AST_JMP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && jmp_i && !restart_i && !irq_i && !ret_i && !call_i
    |=> pc_o == {$past(page_q), $past(target_i)}); // R4
  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && irq_i && !restart_i |=> pc_o == PC_W'(IRQ_VEC)); // R8
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({push, pop, clr}) <= 1); // R9
endmodule

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv = 0, rstr = 0, irq = 0, ret = 0, call = 0, jmp = 0, pwr = 0;
  logic [9:0]  tgt = '0;
  logic [1:0]  pg = '0;
  logic [11:0] pc;
  int checks = 0, errors = 0;
  logic [11:0] cur;
  logic [11:0] saved [9];

  always #4 clk = ~clk;

  pc_stack_unit i_pc_stack_unit (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .restart_i(rstr), .irq_i(irq),
    .ret_i(ret), .call_i(call), .jmp_i(jmp), .target_i(tgt),
    .page_wr_i(pwr), .page_i(pg), .pc_o(pc)
  );

  task automatic chk(input string req, input logic [11:0] exp);
    checks++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s: pc_o=%h expected=%h", req, pc, exp);
    end
  endtask

  // inputs set after a falling edge, result sampled at the following falling edge
  task automatic drive(input logic a_adv, a_rstr, a_irq, a_ret, a_call, a_jmp,
                       input logic a_pwr, input logic [1:0] a_pg, input logic [9:0] a_tgt);
    adv = a_adv; rstr = a_rstr; irq = a_irq; ret = a_ret; call = a_call;
    jmp = a_jmp; pwr = a_pwr; pg = a_pg; tgt = a_tgt;
    @(negedge clk);
    adv = 0; rstr = 0; irq = 0; ret = 0; call = 0; jmp = 0; pwr = 0;
  endtask

  task automatic inc1();                   drive(1,0,0,0,0,0,0,2'd0,10'd0); endtask
  task automatic jmp_to(input logic [9:0] t);  drive(1,0,0,0,0,1,0,2'd0,t); endtask
  task automatic call_to(input logic [9:0] t); drive(1,0,0,0,1,0,0,2'd0,t); endtask
  task automatic ret1();                   drive(1,0,0,1,0,0,0,2'd0,10'd0); endtask
  task automatic set_page(input logic [1:0] p); drive(0,0,0,0,0,0,1,p,10'd0); endtask

  task automatic t_reset();
    chk("R1 reset value", 12'h000);
    inc1(); chk("R2 first step", 12'h001);
  endtask

  task automatic t_increment();
    inc1(); inc1(); inc1(); chk("R2 three steps", 12'h004);
    set_page(2'd3);
    jmp_to(10'h3FF); chk("R4 jump to page 3 top", 12'hFFF);
    inc1(); chk("R2 wrap FFF->000", 12'h000);
  endtask

  task automatic t_hold();
    drive(0,0,1,1,1,1,0,2'd0,10'h155); chk("R3 strobes ignored without adv", 12'h000);
    @(negedge clk); chk("R3 idle cycle holds", 12'h000);
  endtask

  task automatic t_page();
    drive(1,0,0,0,0,1,1,2'd1,10'h005); chk("R5 same-cycle write uses old page", 12'hC05);
    jmp_to(10'h005); chk("R5 new page applies", 12'h405);
  endtask

  task automatic t_call_ret();
    call_to(10'h010); chk("R6 call target", 12'h410);
    call_to(10'h020); chk("R6 nested call target", 12'h420);
    ret1(); chk("R7 inner return", 12'h411);
    ret1(); chk("R7 outer return", 12'h406);
  endtask

  task automatic t_irq();
    drive(1,0,1,0,0,0,0,2'd0,10'd0); chk("R8 vector", 12'h008);
    inc1(); chk("R2 step in handler", 12'h009);
    ret1(); chk("R8 return to pc+1", 12'h407);
  endtask

  task automatic t_priority();
    drive(1,0,1,1,1,1,0,2'd0,10'h0AA); chk("R9 irq wins", 12'h008);
    drive(1,0,0,1,1,1,0,2'd0,10'h0AA); chk("R9 ret beats call/jmp", 12'h408);
    drive(1,0,0,0,1,1,0,2'd0,10'h100); chk("R9 call beats jmp", 12'h500);
    ret1(); chk("R9 call pushed", 12'h409);
  endtask

  task automatic t_overflow();
    drive(0,1,0,0,0,0,0,2'd0,10'd0); chk("R1 restart without adv", 12'h000);
    cur = 12'h000;
    for (int k = 0; k < 9; k++) begin
      saved[k] = cur + 12'd1;
      call_to(10'(10'h040 + k * 16));
      cur = {2'b01, 10'(10'h040 + k * 16)};
      chk("R6 chain call", cur);
    end
    for (int k = 8; k >= 1; k--) begin
      ret1(); chk("R10 return order", saved[k]);
    end
    ret1(); chk("R10 wrapped extra return", saved[8]);
  endtask

  task automatic t_restart_irq();
    call_to(10'h003); chk("R6 call before restart", 12'h403);
    drive(1,1,1,0,0,0,0,2'd0,10'd0); chk("R11 restart beats irq", 12'h000);
    ret1(); chk("R11 pointer cleared, reads slot 7", saved[7]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_increment();
    t_hold();
    t_page();
    t_call_ret();
    t_irq();
    t_priority();
    t_overflow();
    t_restart_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule